// File: doc/BRIEF.md
# Wait-Stretched Clock Divider

This block turns a fast input clock into the two half-rate clocks a processor core runs on. The timing clock toggles on every input clock edge and never stops outside reset. The processor clock has the same frequency and phase, but a wait request can hold it low. Each held period stretches the current machine cycle by one full timing-clock period, and the timing clock keeps running the whole time. Every rising edge of the processor clock starts a machine cycle. The block marks each such edge with a one-input-clock cycle-start pulse, so logic in the input-clock domain can act on cycle boundaries.

The block also qualifies an asynchronous active-high reset request. The request passes through a synchronizer chain. A minimum-length filter then accepts it only after it has been seen high on a set number of consecutive input clock edges, so short glitches are dropped. The qualified core reset is released on an input clock edge. While the core reset is active, both divided clocks are driven low.

Top module: `wait_clk_div`

## Requirements
- R1: Outside core reset, `tclk_o` inverts on every rising edge of `clk_in`, so it runs at half the input clock frequency.
- R2: `pclk_o` goes high only on the edge where `tclk_o` goes from 0 to 1, and it always returns to 0 on the following edge.
- R3: `wait_in` is sampled on the edges where `tclk_o` is 0 (the edges where the timing clock rises). If it is 1 there, `pclk_o` stays 0 for that whole timing-clock period. Each such sample adds one extra timing-clock period to the machine cycle.
- R4: The value of `wait_in` on edges where `tclk_o` is 1 has no effect on `pclk_o`, `tclk_o` or `cycle_start_o`.
- R5: `tclk_o` keeps inverting on every edge while `wait_in` is held high.
- R6: `cycle_start_o` is 1 exactly during the input clock cycles in which `pclk_o` has just risen. It is 0 through every wait-extended period.
- R7: Let rst_in be sampled on edge n. `core_rst_o` is 1 after edge n exactly when `rst_in` was sampled 1 on each of the `RST_MIN_CYCLES` consecutive edges ending `SYNC_STAGES` edges before edge n. A request shorter than `RST_MIN_CYCLES` edges is ignored.
- R8: After any edge at which `core_rst_o` was 1, `tclk_o`, `pclk_o` and `cycle_start_o` are 0.
- R9: On the first edge after `core_rst_o` returns to 0, `tclk_o` rises. `pclk_o` rises with it unless `wait_in` is 1 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, twice the processor clock rate |
| rst_in | input | 1 | Asynchronous active-high reset request |
| wait_in | input | 1 | Active-high request to stretch the current machine cycle |
| core_rst_o | output | 1 | Qualified core reset, active high, synchronous to `clk_in` |
| tclk_o | output | 1 | Free-running half-rate timing clock |
| pclk_o | output | 1 | Half-rate processor clock, held low during wait |
| cycle_start_o | output | 1 | One-input-clock pulse at each processor clock rising edge |

## Verification
The bench builds the block with `SYNC_STAGES = 3` and `RST_MIN_CYCLES = 5`, not the defaults. With a three-stage chain, the latency is visibly different from a two-flop synchronizer. With a five-edge minimum, the bench can drive requests of four and five edges to probe the exact acceptance threshold. These values also put the reset release SYNC_STAGES edges after the request drops, which exposes off-by-one errors in both the synchronizer and the filter. Wait is driven only on rising-slot edges, only on falling-slot edges, as a long hold and as a sparse pattern. These patterns separate sampling-phase mistakes from extension-length mistakes.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  // State of the divided clock outputs, one flop per field.
  typedef struct packed {
    logic tclk;
    logic pclk;
    logic cstart;
  } phase_state_t;

  localparam phase_state_t PHASE_IDLE = '{tclk: 1'b0, pclk: 1'b0, cstart: 1'b0};

  // Next divided-clock state. The rising slot is an edge where the timing
  // clock is currently low; only there can the processor clock rise.
  function automatic phase_state_t phase_step(phase_state_t cur, logic hold_req,
                                              logic in_rst);
    phase_state_t nxt;
    nxt = PHASE_IDLE;
    if (!in_rst) begin
      nxt.tclk   = ~cur.tclk;
      nxt.pclk   = ~cur.tclk & ~hold_req;
      nxt.cstart = ~cur.tclk & ~hold_req;
    end
    return nxt;
  endfunction

  // Saturating run-length step: clears when the level drops, otherwise
  // counts up and stops at the limit.
  function automatic logic [31:0] run_step(logic [31:0] cur, logic level,
                                           logic [31:0] lim);
    if (!level) return 32'd0;
    if (cur >= lim) return cur;
    return cur + 32'd1;
  endfunction

endpackage

// File: rtl/wcd_sync_chain.sv
module wcd_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) sh_q <= d;
    end else begin : g_chain
      always_ff @(posedge clk) sh_q <= {sh_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wcd_rst_filter.sv
module wcd_rst_filter #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic level,
  output logic accepted
);
  import wcd_pkg::*;

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          acc_q;

  always_comb begin
    run_d = CW'(run_step(32'(run_q), level, 32'(MIN_CYC)));
  end

  always_ff @(posedge clk) begin
    run_q <= run_d;
    acc_q <= level && (run_d >= LIM);
  end

  assign accepted = acc_q;
endmodule

// File: rtl/wcd_phase_gen.sv
module wcd_phase_gen (
  input  logic clk,
  input  logic in_rst,
  input  logic wait_req,
  output logic tclk,
  output logic pclk,
  output logic cstart,
  output logic rise_slot
);
  import wcd_pkg::*;

  phase_state_t st_q;
  phase_state_t st_d;
  logic         hold_now;

  // Wait only matters on the edge where the timing clock would rise.
  assign rise_slot = ~st_q.tclk;
  assign hold_now  = rise_slot & wait_req;

  always_comb begin
    st_d = phase_step(st_q, hold_now, in_rst);
  end

  always_ff @(posedge clk) begin
    st_q <= st_d;
  end

  assign tclk   = st_q.tclk;
  assign pclk   = st_q.pclk;
  assign cstart = st_q.cstart;
endmodule

// File: rtl/wait_clk_div.sv
module wait_clk_div #(
  parameter int SYNC_STAGES    = 2,
  parameter int RST_MIN_CYCLES = 4
) (
  input  logic clk_in,
  input  logic rst_in,
  input  logic wait_in,
  output logic core_rst_o,
  output logic tclk_o,
  output logic pclk_o,
  output logic cycle_start_o
);
  // Named internal events, brought out for the bound checker.
  logic rst_level;
  logic rst_accepted;
  logic rise_slot;

  wcd_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_in),
    .d   (rst_in),
    .q   (rst_level)
  );

  wcd_rst_filter #(.MIN_CYC(RST_MIN_CYCLES)) u_filter (
    .clk      (clk_in),
    .level    (rst_level),
    .accepted (rst_accepted)
  );

  wcd_phase_gen u_phase (
    .clk       (clk_in),
    .in_rst    (rst_accepted),
    .wait_req  (wait_in),
    .tclk      (tclk_o),
    .pclk      (pclk_o),
    .cstart    (cycle_start_o),
    .rise_slot (rise_slot)
  );

  assign core_rst_o = rst_accepted;
endmodule

// File: rtl/wait_clk_div_checks.sv
module wait_clk_div_checks #(
  parameter int SYNC_STAGES    = 2,
  parameter int RST_MIN_CYCLES = 4
) (
  input logic clk_in,
  input logic wait_in,
  input logic core_rst_o,
  input logic tclk_o,
  input logic pclk_o,
  input logic cycle_start_o,
  input logic rst_level,
  input logic rise_slot
);
  localparam int AGE_LIM = SYNC_STAGES + RST_MIN_CYCLES + 2;
  localparam int AW      = $clog2(AGE_LIM + 1);
  localparam int RW      = $clog2(RST_MIN_CYCLES + 1);

  logic [AW-1:0] age_q = '0;
  logic [RW-1:0] lvl_run_q = '0;
  logic          armed;

  always_ff @(posedge clk_in) begin
    if (age_q != AW'(AGE_LIM)) age_q <= age_q + 1'b1;
    if (!rst_level)                           lvl_run_q <= '0;
    else if (lvl_run_q != RW'(RST_MIN_CYCLES)) lvl_run_q <= lvl_run_q + 1'b1;
  end

  assign armed = (age_q == AW'(AGE_LIM));

  assert_tclk_toggles_R1: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    !$past(core_rst_o) |-> (tclk_o != $past(tclk_o)));

  assert_pclk_rises_with_tclk_R2: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    $rose(pclk_o) |-> $rose(tclk_o));

  assert_pclk_one_cycle_high_R2: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    pclk_o |=> !pclk_o);

  assert_wait_holds_low_R3: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    (rise_slot && wait_in) |=> !pclk_o);

  assert_free_slot_rises_R3: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    (rise_slot && !wait_in) |=> pclk_o);

  assert_tclk_runs_in_wait_R5: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    wait_in |=> (tclk_o != $past(tclk_o)));

  assert_cstart_marks_rise_R6: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    cycle_start_o |-> $rose(pclk_o));

  assert_rise_has_cstart_R6: assert property (@(posedge clk_in)
    disable iff (core_rst_o || !armed)
    $rose(pclk_o) |-> cycle_start_o);

  assert_reset_needs_min_run_R7: assert property (@(posedge clk_in)
    disable iff (!armed)
    $rose(core_rst_o) |-> (lvl_run_q == RW'(RST_MIN_CYCLES)));

  assert_reset_release_R7: assert property (@(posedge clk_in)
    disable iff (!armed)
    $fell(rst_level) |=> !core_rst_o);

  assert_clocks_low_in_reset_R8: assert property (@(posedge clk_in)
    disable iff (!armed)
    core_rst_o |=> (!tclk_o && !pclk_o && !cycle_start_o));
endmodule

bind wait_clk_div wait_clk_div_checks #(
  .SYNC_STAGES    (SYNC_STAGES),
  .RST_MIN_CYCLES (RST_MIN_CYCLES)
) u_checks (
  .clk_in        (clk_in),
  .wait_in       (wait_in),
  .core_rst_o    (core_rst_o),
  .tclk_o        (tclk_o),
  .pclk_o        (pclk_o),
  .cycle_start_o (cycle_start_o),
  .rst_level     (rst_level),
  .rise_slot     (rise_slot)
);

// File: tb/test_wait_clk_div.sv
`timescale 1ns/1ps
module test_wait_clk_div;
  localparam int SYNC = 3;
  localparam int MINC = 5;
  localparam int HW   = SYNC + MINC;

  logic clk_in = 1'b0;
  logic rst_in = 1'b1;
  logic wait_in = 1'b0;
  logic core_rst_o, tclk_o, pclk_o, cycle_start_o;

  always #2.5 clk_in = ~clk_in;

  wait_clk_div #(.SYNC_STAGES(SYNC), .RST_MIN_CYCLES(MINC)) i_wait_clk_div (
    .clk_in        (clk_in),
    .rst_in        (rst_in),
    .wait_in       (wait_in),
    .core_rst_o    (core_rst_o),
    .tclk_o        (tclk_o),
    .pclk_o        (pclk_o),
    .cycle_start_o (cycle_start_o)
  );

  typedef struct {
    logic  core, tclk, pclk, cs;
    string t_core, t_tclk, t_pclk, t_cs;
  } exp_t;

  exp_t q[$];
  exp_t item;
  int   checks = 0;
  int   errors = 0;
  bit   chk_en = 1'b0;
  bit   done   = 1'b0;

  // Bench model state: values after the most recent edge.
  logic [HW-1:0] hist = '0;
  logic m_core = 1'b0, m_tclk = 1'b0;

  task automatic cmp(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // Driver: applies one edge worth of inputs and pushes the expectation.
  task automatic tick(logic r, logic w);
    exp_t e;
    logic n_core;
    @(negedge clk_in);
    rst_in  = r;
    wait_in = w;
    @(posedge clk_in);
    hist   = {hist[HW-2:0], r};
    n_core = &hist[HW-1:SYNC];
    e.core   = n_core;
    e.t_core = "R7";
    e.tclk   = m_core ? 1'b0 : ~m_tclk;
    e.pclk   = m_core ? 1'b0 : (~m_tclk & ~w);
    e.cs     = e.pclk;
    e.t_cs   = "R6";
    if (m_core) begin
      e.t_tclk = "R8"; e.t_pclk = "R8";
    end else if (!m_tclk && hist[SYNC] == 1'b0 && m_tclk == 1'b0 && e.tclk && q.size() >= 0 && first_after_rst) begin
      e.t_tclk = "R9"; e.t_pclk = "R9";
    end else begin
      e.t_tclk = w ? "R5" : "R1";
      e.t_pclk = w ? (m_tclk ? "R4" : "R3") : "R2";
    end
    first_after_rst = m_core && !n_core;
    m_core = n_core;
    m_tclk = e.tclk;
    q.push_back(e);
  endtask

  bit first_after_rst = 1'b0;

  // Monitor: pops expectations and compares away from the active edge.
  always @(negedge clk_in) begin
    if (q.size() > 0) begin
      item = q.pop_front();
      if (chk_en) begin
        cmp(item.t_core, "core_rst_o",    core_rst_o,    item.core);
        cmp(item.t_tclk, "tclk_o",        tclk_o,        item.tclk);
        cmp(item.t_pclk, "pclk_o",        pclk_o,        item.pclk);
        cmp(item.t_cs,   "cycle_start_o", cycle_start_o, item.cs);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_in);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Initial reset; checking starts once the model history is full (R7, R8).
    repeat (16) tick(1'b1, 1'b0);
    chk_en = 1'b1;
    repeat (6) tick(1'b1, 1'b0);
    // Release and free run (R9, R1, R2, R6).
    repeat (14) tick(1'b0, 1'b0);
    // Long wait hold (R3, R5).
    repeat (7) tick(1'b0, 1'b1);
    repeat (6) tick(1'b0, 1'b0);
    // Wait only on edges where tclk is high: ignored (R4).
    repeat (12) tick(1'b0, m_tclk);
    // Wait only on rising-slot edges: every rise blocked (R3).
    repeat (12) tick(1'b0, ~m_tclk);
    repeat (4) tick(1'b0, 1'b0);
    // Request one edge short of the minimum: ignored (R7).
    repeat (MINC - 1) tick(1'b1, 1'b0);
    repeat (12) tick(1'b0, 1'b0);
    // Request of exactly the minimum: accepted, then released (R7, R8, R9).
    repeat (MINC) tick(1'b1, 1'b0);
    repeat (14) tick(1'b0, 1'b0);
    // Reset with wait across release: first rise blocked (R9, R3).
    repeat (10) tick(1'b1, 1'b1);
    repeat (SYNC + 3) tick(1'b0, 1'b1);
    repeat (6) tick(1'b0, 1'b0);
    // Sparse wait pattern (R3, R4, R6).
    for (int i = 0; i < 30; i++) tick(1'b0, (i % 3) == 0);
    repeat (3) tick(1'b0, 1'b0);
    @(negedge clk_in);
    @(negedge clk_in);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule